// File: doc/BRIEF.md
# Four-Slot Conversion Sequencer for an Eight-Channel Converter

This block is the digital control logic of an eight-channel, 8-bit analog-to-digital converter. Software reaches it over a small register bus. The block drives a channel number and a sample-window strobe to an external converter core, and on the last cycle of each conversion it latches the code the core returns into one of four result slots.

A write to the control register starts a cycle of four conversions. There are two ways to fill the four slots: repeat one channel four times, or step through one group of four adjacent channels in ascending order. A cycle either runs once after the write or repeats without end. A completion flag rises only when all four slots hold a conversion from the current run. An option register holds a power-up bit, and no conversion starts while that bit is clear.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register address (0 to 7) reads 0 and the sample strobe is low.
- R2: Control register at address 0 reads {flag, 0, scan, group, sel[3:0]}, that is bit 7 flag, bit 6 zero, bit 5 scan, bit 4 group mode, bits 3..0 channel select. Writes to bits 7 and 6 have no effect.
- R3: Option register at address 5 reads power-up in bit 7, clock select in bit 6 and zeros below. Writing it never starts a conversion.
- R4: A control write while powered clears the flag and restarts at slot 1, abandoning any run in progress.
- R5: While power-up is 0, no conversion starts and the strobe stays low. Clearing power-up stops a running sequence.
- R6: Each conversion lasts 32 clocks. The strobe is high for its first 12 clocks, and the code is latched on its 32nd clock.
- R7: With group mode 0, all four conversions use channel sel[2:0]. sel[3] is ignored.
- R8: With group mode 1, slots 1..4 receive channels {sel[2],00} to {sel[2],11} in ascending order. sel[1:0] are ignored.
- R9: The flag reads 0 during a cycle and rises on the edge that latches slot 4, 128 clocks after the control write edge.
- R10: With scan 0 the sequencer stops after slot 4. With scan 1 it restarts at slot 1, overwriting each slot as its conversion ends, and the flag stays 1.
- R11: Result slots 1..4 read at addresses 1..4 and ignore writes. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| conv_chan | output | 3 | Channel presented to the converter core |
| sample_win | output | 1 | High during the sample window of each conversion |
| conv_code | input | 8 | Code returned by the converter core |

## Verification
The hardest situations to reach are a restart that lands partway through a run and the repeating mode's second cycle. In both, the value in each slot has to show which conversion produced it. The bench therefore makes the converter code carry the channel in its upper bits and, in its lower bits, a count of sample-window rising edges seen since the last control write. A stale slot, a slot filled out of order, or an overwrite in the wrong place then shows up as a wrong number. Restarts are issued 50 clocks into a repeating run, and slots are read both after the first full cycle and after the second.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int ADDR_W    = 3;
  localparam int CHAN_W    = 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd0;
  localparam logic [ADDR_W-1:0] OPT_ADDR  = 3'd5;

  typedef struct packed {
    logic       scan;
    logic       group;
    logic [3:0] sel;
  } ctrl_t;

  function automatic logic [CHAN_W-1:0] slot_channel(input ctrl_t c, input logic [SLOT_W-1:0] slot);
    if (c.group) return {c.sel[2], slot};
    return c.sel[2:0];
  endfunction

  function automatic logic [7:0] ctrl_image(input logic flag, input ctrl_t c);
    return {flag, 1'b0, c.scan, c.group, c.sel};
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [7:0]                     bus_wdata,
  input  logic                           flag,
  input  logic [NUM_SLOTS-1:0][CODE_W-1:0] slot_data,
  output logic [7:0]                     bus_rdata,
  output ctrl_t                          ctrl,
  output logic                           pwr_on,
  output logic                           ctrl_wr
);
  logic csel;
  logic opt_wr;

  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == CTRL_ADDR);
  assign opt_wr  = bus_sel && bus_wr && (bus_addr == OPT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      pwr_on <= 1'b0;
      csel   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata[5:0]);
      if (opt_wr) begin
        pwr_on <= bus_wdata[7];
        csel   <= bus_wdata[6];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) bus_rdata = ctrl_image(flag, ctrl);
    if (bus_addr == OPT_ADDR)  bus_rdata = {pwr_on, csel, 6'b0};
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (bus_addr == ADDR_W'(s + 1)) bus_rdata = 8'(slot_data[s]);
    end
  end
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC   = 32,
  parameter int SAMPLE_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              pwr_on,
  input  logic              scan,
  output logic              busy,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              sample_win,
  output logic              conv_done,
  output logic              flag
);
  localparam int CNT_W = $clog2(CONV_CYC);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [CNT_W-1:0] cnt;
  logic             last_cyc;

  assign last_cyc   = (cnt == CNT_W'(CONV_CYC - 1));
  assign conv_done  = busy && last_cyc;
  assign sample_win = busy && (cnt < CNT_W'(SAMPLE_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      slot_idx <= '0;
      flag     <= 1'b0;
    end else if (ctrl_wr) begin
      busy     <= pwr_on;
      cnt      <= '0;
      slot_idx <= '0;
      flag     <= 1'b0;
    end else if (!pwr_on) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (last_cyc) begin
        cnt <= '0;
        if (slot_idx == LAST_SLOT) begin
          flag     <= 1'b1;
          slot_idx <= '0;
          if (!scan) busy <= 1'b0;
        end else begin
          slot_idx <= slot_idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_NO_RUN_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !busy); // R5
  AST_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !flag); // R4
  AST_FLAG_AFTER_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(conv_done) && $past(slot_idx) == LAST_SLOT)); // R9
  AST_LATCH_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> !sample_win); // R6
  AST_SINGLE_RUN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && slot_idx == LAST_SLOT && !scan && !ctrl_wr) |=> !busy); // R10
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             conv_done,
  input  logic [SLOT_W-1:0]                slot_idx,
  input  logic [CODE_W-1:0]                conv_code,
  output logic [NUM_SLOTS-1:0][CODE_W-1:0] slot_data
);
  logic [NUM_SLOTS-1:0] slot_we;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_we[g] = conv_done && (slot_idx == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)          slot_data[g] <= '0;
      else if (slot_we[g]) slot_data[g] <= conv_code;
    end
  end

  AST_ONE_SLOT_PER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we)); // R10
  AST_LATCH_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> $countones(slot_we) == 1); // R6
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int CONV_CYC   = 32,
  parameter int SAMPLE_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              sample_win,
  input  logic [CODE_W-1:0] conv_code
);
  ctrl_t                            ctrl;
  logic                             pwr_on;
  logic                             ctrl_wr;
  logic                             busy;
  logic                             conv_done;
  logic                             flag;
  logic [SLOT_W-1:0]                slot_idx;
  logic [NUM_SLOTS-1:0][CODE_W-1:0] slot_data;

  adc_seq_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag(flag),
    .slot_data(slot_data), .bus_rdata(bus_rdata), .ctrl(ctrl),
    .pwr_on(pwr_on), .ctrl_wr(ctrl_wr)
  );

  adc_seq_engine #(.CONV_CYC(CONV_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .pwr_on(pwr_on),
    .scan(ctrl.scan), .busy(busy), .slot_idx(slot_idx),
    .sample_win(sample_win), .conv_done(conv_done), .flag(flag)
  );

  adc_seq_results #(.CODE_W(CODE_W)) u_results (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .slot_idx(slot_idx),
    .conv_code(conv_code), .slot_data(slot_data)
  );

  assign conv_chan = slot_channel(ctrl, slot_idx);

  AST_SINGLE_CHANNEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctrl.group) |-> conv_chan == ctrl.sel[2:0]); // R7
  AST_GROUP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl.group) |-> conv_chan[2] == ctrl.sel[2]); // R8
endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] conv_chan;
  logic       sample_win;
  logic [7:0] conv_code;
  int         k;
  logic       sw_q;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_chan(conv_chan), .sample_win(sample_win), .conv_code(conv_code)
  );

  // converter model: channel in the top bits, sample-window count in the low bits
  always @(posedge clk) begin
    if (!rst_n || (bus_sel && bus_wr && bus_addr == 3'd0)) k <= 0;
    else if (sample_win && !sw_q) k <= k + 1;
    sw_q <= sample_win;
  end
  assign conv_code = {conv_chan, k[4:0]};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] exp_code(input logic [7:0] c, input int s, input int kk);
    logic [2:0] ch;
    ch = c[4] ? {c[2], 2'(s)} : c[2:0];
    return {ch, 5'(kk)};
  endfunction

  task automatic count_win(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (sample_win) hi++;
      cyc(1);
    end
  endtask

  task automatic run_once(input logic [7:0] c);
    logic [7:0] d;
    int hi;
    wr(3'd0, c);
    cyc(127);
    rd(3'd0, d); chk("R9 flag low before slot 4", int'(d[7]), 0);
    cyc(1);
    rd(3'd0, d); chk("R9 flag high after slot 4", int'(d[7]), 1);
    chk("R2 control readback", int'(d), int'({2'b10, c[5:0]}));
    for (int s = 0; s < 4; s++) begin
      rd(3'(s + 1), d);
      chk(c[4] ? "R8 group slot" : "R7 single slot", int'(d), int'(exp_code(c, s, s + 1)));
    end
    count_win(40, hi);
    chk("R10 single run stops", hi, 0);
  endtask

  initial begin
    logic [7:0] d;
    int hi;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); chk("R1 reset register", int'(d), 0);
    end
    chk("R1 reset strobe", int'(sample_win), 0);

    // unpowered: nothing starts
    wr(3'd0, 8'h00);
    count_win(40, hi);
    chk("R5 no start unpowered", hi, 0);
    rd(3'd0, d); chk("R5 flag stays low unpowered", int'(d[7]), 0);

    wr(3'd5, 8'hFF);
    rd(3'd5, d); chk("R3 option readback", int'(d), 8'hC0);
    count_win(40, hi);
    chk("R3 option write does not start", hi, 0);
    wr(3'd5, 8'h80);

    // window and period
    wr(3'd0, 8'h03);
    chk("R6 strobe high after write edge", int'(sample_win), 1);
    count_win(32, hi);
    chk("R6 strobe length", hi, 12);
    chk("R6 next conversion at 32 clocks", int'(sample_win), 1);
    cyc(96);
    rd(3'd0, d); chk("R9 flag after four conversions", int'(d[7]), 1);

    // flag and bit 6 not writable
    wr(3'd0, 8'hC1);
    rd(3'd0, d); chk("R2 bits 7 and 6 ignored on write", int'(d), 8'h01);
    cyc(130);

    // sweep every select code in both fill modes
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        run_once(8'((m << 4) | s));

    // result slots are read-only, unused addresses read 0
    rd(3'd1, d);
    wr(3'd1, ~d);
    begin
      logic [7:0] d2;
      rd(3'd1, d2); chk("R11 slot ignores write", int'(d2), int'(d));
    end
    rd(3'd6, d); chk("R11 address 6 reads 0", int'(d), 0);
    rd(3'd7, d); chk("R11 address 7 reads 0", int'(d), 0);

    // repeating group mode, upper group
    wr(3'd0, 8'h37);
    cyc(128);
    for (int s = 0; s < 4; s++) begin
      rd(3'(s + 1), d); chk("R10 scan first cycle", int'(d), int'(exp_code(8'h37, s, s + 1)));
    end
    cyc(72);
    rd(3'd0, d); chk("R10 flag stays high in scan", int'(d[7]), 1);
    rd(3'd1, d); chk("R10 slot 1 overwritten", int'(d), int'(exp_code(8'h37, 0, 5)));
    rd(3'd3, d); chk("R10 slot 3 not yet overwritten", int'(d), int'(exp_code(8'h37, 2, 3)));
    cyc(56);
    for (int s = 0; s < 4; s++) begin
      rd(3'(s + 1), d); chk("R10 scan second cycle", int'(d), int'(exp_code(8'h37, s, s + 5)));
    end

    // restart mid-run
    wr(3'd0, 8'h31);
    cyc(50);
    wr(3'd0, 8'h05);
    rd(3'd0, d); chk("R4 restart clears flag", int'(d[7]), 0);
    cyc(127);
    rd(3'd0, d); chk("R4 restarted run not done early", int'(d[7]), 0);
    cyc(1);
    for (int s = 0; s < 4; s++) begin
      rd(3'(s + 1), d); chk("R4 restart refills from slot 1", int'(d), int'(exp_code(8'h05, s, s + 1)));
    end

    // power cleared mid-run
    wr(3'd0, 8'h20);
    cyc(20);
    wr(3'd5, 8'h00);
    cyc(1);
    count_win(80, hi);
    chk("R5 power-down stops run", hi, 0);
    rd(3'd0, d); chk("R5 flag not set after power-down", int'(d[7]), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule